// File: doc/BRIEF.md
# DMA Suspend and NMI Arbiter

This block sits beside a multi-channel DMA engine and decides three things: whether the engine is powered (clock enable and channel-register reset), whether transfers are currently suspended by a sticky stop flag, and how a non-maskable interrupt request is handed to the CPU while a DMA cycle may be in flight. Software drives it through write strobes: a power bit, a stop trigger, a resume trigger and an NMI wait-mode bit. The two triggers are not stored, so a read of either returns 0. The stop flag and the wait-mode bit are available as status outputs.

Every output is registered. Simultaneous events are resolved by fixed priorities. Power-off beats everything. The resume trigger beats both the stop trigger and an NMI that would otherwise set the stop flag. In wait mode, an NMI that arrives during a DMA cycle is held and released once the cycle ends. In the default mode, it is passed to the CPU at once.

Top module: `dma_suspend_ctrl`

## Requirements
- R1: After reset, `dma_clk_en`, `stopped`, `nmi_wait_mode`, `resume_pulse` and `nmi_accept` are 0, and every bit of `chan_ctl_rst` is 1.
- R2: A `pwr_wr` strobe loads `pwr_wdata` into the power bit on the clock edge. From the next cycle, `dma_clk_en` equals that bit and every bit of `chan_ctl_rst` equals its inverse.
- R3: While powered, a `stop_set_wr` strobe without `stop_clr_wr` sets `stopped` on the next edge. `stopped` then stays set until a stop-clear write or power-off.
- R4: While powered, a `stop_clr_wr` strobe clears `stopped` on the next edge and raises `resume_pulse` for exactly that one cycle. This holds even if `stop_set_wr` is strobed in the same cycle.
- R5: An `nmi_req` sampled while `dma_busy` is high and powered sets `stopped` on the next edge, unless `stop_clr_wr` is strobed in the same cycle. In that case `stopped` ends cleared.
- R6: With `nmi_wait_mode` = 0, an `nmi_req` produces `nmi_accept` high in the following cycle, whatever the state of `dma_busy`.
- R7: With `nmi_wait_mode` = 1, an `nmi_req` sampled while powered and `dma_busy` is high is held pending, and `nmi_accept` stays low while `dma_busy` remains high. At the first edge where `dma_busy` is sampled low, the pending request is cleared, and `nmi_accept` is high for that following cycle.
- R8: An `nmi_req` sampled while `dma_busy` is low (or while unpowered) produces `nmi_accept` in the following cycle in either mode, and leaves `stopped` unchanged.
- R9: A `mode_wr` strobe loads `mode_wdata` into `nmi_wait_mode` only when the power bit is 0. While the power bit is 1, the write is ignored.
- R10: While the power bit is 0, `stopped` and any pending NMI are cleared on the next edge, `stop_set_wr` has no effect, `stop_clr_wr` raises no `resume_pulse`, and `dma_busy` is treated as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_wr | input | 1 | Write strobe for the power bit |
| pwr_wdata | input | 1 | Power bit value |
| stop_set_wr | input | 1 | Stop trigger strobe |
| stop_clr_wr | input | 1 | Resume trigger strobe |
| mode_wr | input | 1 | Write strobe for the NMI wait-mode bit |
| mode_wdata | input | 1 | NMI wait-mode value |
| nmi_req | input | 1 | NMI request, one event per high cycle |
| dma_busy | input | 1 | Engine reports a DMA cycle in progress |
| dma_clk_en | output | 1 | Clock enable for the DMA engine |
| chan_ctl_rst | output | NUM_CH | Synchronous reset per channel control register |
| stopped | output | 1 | Sticky stop flag; blocks new transfers |
| resume_pulse | output | 1 | One-cycle pulse resuming suspended transfers |
| nmi_accept | output | 1 | NMI handed to the CPU |
| nmi_wait_mode | output | 1 | Current NMI wait-mode bit |

## Verification
The bench builds the block with `NUM_CH` = 3, a non-default channel count. This checks that the per-channel reset vector follows the parameter at an odd width. Because the arbitration logic has no other parameters, that one build reaches every priority collision, including the resume trigger against the stop trigger and the resume trigger against an NMI that would stop transfers. It also reaches wait-mode NMI hold-and-release and power-off flushing, all through random strobes mixed with directed sequences.

// File: rtl/dma_susp_pkg.sv
package dma_susp_pkg;

    typedef struct packed {
        logic pwr;
        logic wait_mode;
    } pwr_state_t;

    typedef struct packed {
        logic stopped;
        logic resume;
    } stop_state_t;

    typedef struct packed {
        logic pend;
        logic accept;
    } nmi_state_t;

endpackage

// File: rtl/dss_power.sv
module dss_power
    import dma_susp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_wr,
    input  logic              pwr_wdata,
    input  logic              mode_wr,
    input  logic              mode_wdata,
    output logic              pwr_on,
    output logic              wait_mode,
    output logic [NUM_CH-1:0] chan_rst
);

    pwr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_wr) begin
            st_d.pwr = pwr_wdata;
        end
        // mode bit is locked while the engine is powered
        if (mode_wr && !st_q.pwr) begin
            st_d.wait_mode = mode_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_on    = st_q.pwr;
    assign wait_mode = st_q.wait_mode;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_rst
        assign chan_rst[c] = ~st_q.pwr;
    end

    // R9
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pwr |=> $stable(st_q.wait_mode));

    // R2
    pwr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_wr |=> (st_q.pwr == $past(pwr_wdata)));

endmodule

// File: rtl/dss_stop.sv
module dss_stop
    import dma_susp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic stop_set_wr,
    input  logic stop_clr_wr,
    input  logic nmi_stop_evt,
    output logic stopped,
    output logic resume_pulse
);

    stop_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.resume = 1'b0;
        if (!pwr_on) begin
            st_d.stopped = 1'b0;
        end else if (stop_clr_wr) begin
            st_d.stopped = 1'b0;
            st_d.resume  = 1'b1;
        end else if (stop_set_wr || nmi_stop_evt) begin
            st_d.stopped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stopped      = st_q.stopped;
    assign resume_pulse = st_q.resume;

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && stop_clr_wr) |=> (!st_q.stopped && st_q.resume));

    // R3
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && st_q.stopped && !stop_clr_wr) |=> st_q.stopped);

    // R10
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!st_q.stopped && !st_q.resume));

endmodule

// File: rtl/dss_nmi.sv
module dss_nmi
    import dma_susp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic wait_mode,
    input  logic nmi_req,
    input  logic dma_busy,
    output logic nmi_stop_evt,
    output logic nmi_accept
);

    nmi_state_t st_d, st_q;
    logic       busy_eff;
    logic       defer;

    assign busy_eff     = dma_busy & pwr_on;
    assign defer        = nmi_req & busy_eff & wait_mode;
    assign nmi_stop_evt = nmi_req & busy_eff;

    always_comb begin
        st_d        = st_q;
        st_d.accept = nmi_req & ~defer;
        if (!pwr_on) begin
            st_d.pend = 1'b0;
        end else if (defer) begin
            st_d.pend = 1'b1;
        end else if (st_q.pend && !busy_eff) begin
            st_d.pend   = 1'b0;
            st_d.accept = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_accept = st_q.accept;

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && st_q.pend && !dma_busy) |=> (st_q.accept && !st_q.pend));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && wait_mode && dma_busy && !st_q.pend && !nmi_req) |=> !st_q.accept);

    // R10
    pend_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !st_q.pend);

endmodule

// File: rtl/dma_suspend_ctrl.sv
module dma_suspend_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_wr,
    input  logic              pwr_wdata,
    input  logic              stop_set_wr,
    input  logic              stop_clr_wr,
    input  logic              mode_wr,
    input  logic              mode_wdata,
    input  logic              nmi_req,
    input  logic              dma_busy,
    output logic              dma_clk_en,
    output logic [NUM_CH-1:0] chan_ctl_rst,
    output logic              stopped,
    output logic              resume_pulse,
    output logic              nmi_accept,
    output logic              nmi_wait_mode
);

    logic pwr_on;
    logic wait_mode;
    logic nmi_stop_evt;

    dss_power #(.NUM_CH(NUM_CH)) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_wr     (pwr_wr),
        .pwr_wdata  (pwr_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .pwr_on     (pwr_on),
        .wait_mode  (wait_mode),
        .chan_rst   (chan_ctl_rst)
    );

    dss_nmi u_nmi (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_on       (pwr_on),
        .wait_mode    (wait_mode),
        .nmi_req      (nmi_req),
        .dma_busy     (dma_busy),
        .nmi_stop_evt (nmi_stop_evt),
        .nmi_accept   (nmi_accept)
    );

    dss_stop u_stop (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_on       (pwr_on),
        .stop_set_wr  (stop_set_wr),
        .stop_clr_wr  (stop_clr_wr),
        .nmi_stop_evt (nmi_stop_evt),
        .stopped      (stopped),
        .resume_pulse (resume_pulse)
    );

    assign dma_clk_en    = pwr_on;
    assign nmi_wait_mode = wait_mode;

    // R5
    nmi_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clk_en && nmi_req && dma_busy && !stop_clr_wr) |=> stopped);

    // R8
    idle_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !dma_busy) |=> nmi_accept);

endmodule

// File: tb/dma_suspend_ctrl_bench.sv
module dma_suspend_ctrl_bench;

    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_wr = 0, pwr_wdata = 0, stop_set_wr = 0, stop_clr_wr = 0;
    logic mode_wr = 0, mode_wdata = 0, nmi_req = 0, dma_busy = 0;
    logic dma_clk_en, stopped, resume_pulse, nmi_accept, nmi_wait_mode;
    logic [NCH-1:0] chan_ctl_rst;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic m_pwr = 0, m_mode = 0, m_stop = 0, m_pend = 0, m_acc = 0, m_res = 0;

    always #4 clk = ~clk;

    dma_suspend_ctrl #(.NUM_CH(NCH)) u_dma_suspend_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
        .stop_set_wr(stop_set_wr), .stop_clr_wr(stop_clr_wr),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .nmi_req(nmi_req),
        .dma_busy(dma_busy), .dma_clk_en(dma_clk_en), .chan_ctl_rst(chan_ctl_rst),
        .stopped(stopped), .resume_pulse(resume_pulse), .nmi_accept(nmi_accept),
        .nmi_wait_mode(nmi_wait_mode)
    );

    function automatic logic exp_stop(logic pwr, logic clr, logic set, logic nmi_busy, logic cur);
        if (!pwr) return 1'b0;
        if (clr) return 1'b0;
        if (set || nmi_busy) return 1'b1;
        return cur;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 clk_en", {7'd0, dma_clk_en}, {7'd0, m_pwr});
        chk("R2 chan_rst", {5'd0, chan_ctl_rst}, {5'd0, {NCH{~m_pwr}}});
        chk("R3 stopped", {7'd0, stopped}, {7'd0, m_stop});
        chk("R4 resume", {7'd0, resume_pulse}, {7'd0, m_res});
        chk("R6 accept", {7'd0, nmi_accept}, {7'd0, m_acc});
        chk("R9 mode", {7'd0, nmi_wait_mode}, {7'd0, m_mode});
    endtask

    // advance one clock: model from current inputs, then compare after edge
    task automatic step();
        logic be, n_pend, n_acc;
        be = dma_busy & m_pwr;
        n_acc = (nmi_req && !(be && m_mode)) || (m_pwr && m_pend && !be && !(nmi_req && be && m_mode));
        if (!m_pwr) n_pend = 1'b0;
        else if (nmi_req && be && m_mode) n_pend = 1'b1;
        else if (m_pend && !be) n_pend = 1'b0;
        else n_pend = m_pend;
        m_stop = exp_stop(m_pwr, stop_clr_wr, stop_set_wr, nmi_req && be, m_stop);
        m_res  = m_pwr && stop_clr_wr;
        if (mode_wr && !m_pwr) m_mode = mode_wdata;
        if (pwr_wr) m_pwr = pwr_wdata;
        m_pend = n_pend;
        m_acc  = n_acc;
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic idle();
        pwr_wr = 0; stop_set_wr = 0; stop_clr_wr = 0; mode_wr = 0; nmi_req = 0;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        #10;
        // R1 reset state
        chk("R1 clk_en", {7'd0, dma_clk_en}, 8'd0);
        chk("R1 chan_rst", {5'd0, chan_ctl_rst}, 8'h07);
        chk("R1 stopped", {7'd0, stopped}, 8'd0);
        chk("R1 accept", {7'd0, nmi_accept}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R9 mode write while unpowered takes effect
        mode_wr = 1; mode_wdata = 1; step(); idle();
        chk("R9 mode loaded", {7'd0, nmi_wait_mode}, 8'd1);
        // R2 power on
        pwr_wr = 1; pwr_wdata = 1; step(); idle();
        chk("R2 powered", {5'd0, chan_ctl_rst}, 8'd0);
        // R9 mode write ignored while powered
        mode_wr = 1; mode_wdata = 0; step(); idle();
        chk("R9 locked", {7'd0, nmi_wait_mode}, 8'd1);
        // R7 deferred NMI during busy
        dma_busy = 1; nmi_req = 1; step(); idle();
        chk("R7 no accept while busy", {7'd0, nmi_accept}, 8'd0);
        chk("R5 nmi sets stopped", {7'd0, stopped}, 8'd1);
        step(); step();
        chk("R7 still held", {7'd0, nmi_accept}, 8'd0);
        dma_busy = 0; step();
        chk("R7 released", {7'd0, nmi_accept}, 8'd1);
        step();
        chk("R7 single pulse", {7'd0, nmi_accept}, 8'd0);
        // R4 simultaneous set and clear
        stop_set_wr = 1; stop_clr_wr = 1; step(); idle();
        chk("R4 clear wins", {7'd0, stopped}, 8'd0);
        chk("R4 resume pulse", {7'd0, resume_pulse}, 8'd1);
        step();
        chk("R4 pulse ends", {7'd0, resume_pulse}, 8'd0);
        // R3 set and hold
        stop_set_wr = 1; step(); idle(); step();
        chk("R3 sticky", {7'd0, stopped}, 8'd1);
        // R5 clear beats NMI stop
        dma_busy = 1; nmi_req = 1; stop_clr_wr = 1; step(); idle();
        chk("R5 clear beats nmi", {7'd0, stopped}, 8'd0);
        dma_busy = 0; step(); step();
        // R8 idle NMI accepted, stopped unchanged
        nmi_req = 1; step(); idle();
        chk("R8 idle accept", {7'd0, nmi_accept}, 8'd1);
        chk("R8 stopped kept", {7'd0, stopped}, 8'd0);
        // R10 power off flushes
        stop_set_wr = 1; dma_busy = 1; nmi_req = 1; step(); idle();
        pwr_wr = 1; pwr_wdata = 0; step(); idle();
        chk("R10 still stopped before flush", {7'd0, stopped}, 8'd1);
        step();
        chk("R10 flushed", {7'd0, stopped}, 8'd0);
        stop_set_wr = 1; step(); idle();
        chk("R10 set ignored", {7'd0, stopped}, 8'd0);
        stop_clr_wr = 1; step(); idle();
        chk("R10 no resume", {7'd0, resume_pulse}, 8'd0);
        // R6 immediate mode: accept even when busy
        mode_wr = 1; mode_wdata = 0; step(); idle();
        pwr_wr = 1; pwr_wdata = 1; step(); idle();
        dma_busy = 1; nmi_req = 1; step(); idle();
        chk("R6 immediate accept", {7'd0, nmi_accept}, 8'd1);
        dma_busy = 0;
        step();

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            pwr_wr      = ($urandom % 40) == 0;
            pwr_wdata   = ($urandom % 4) != 0;
            stop_set_wr = ($urandom % 8) == 0;
            stop_clr_wr = ($urandom % 10) == 0;
            mode_wr     = ($urandom % 12) == 0;
            mode_wdata  = $urandom % 2;
            nmi_req     = ($urandom % 9) == 0;
            if (($urandom % 5) == 0) dma_busy = ~dma_busy;
            step();
        end
        idle();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule